// File: doc/BRIEF.md
# Receive descriptor ring manager

This block runs the hardware side of a packet receive ring. Software places 64-bit buffer descriptors in a small internal ring memory, then rings a doorbell with the number of descriptors it has just posted. Incoming frames arrive as a byte stream, one byte per valid beat, with start-of-frame and end-of-frame markers. The block writes each byte to the payload address taken from the current descriptor. When a buffer fills before the frame ends, the block moves on to the next posted descriptor. It writes back every descriptor it has used, with the byte count and a status code.

Each frame that closes adds one to a completion counter. Software acknowledges finished frames by writing a count, which is subtracted from the counter. An interrupt flag is raised when a completion leaves the count above a programmable watermark, and software clears that flag by writing one to it. A frame that finds no posted descriptor is dropped and counted. Payload and descriptor write-back leave the block as plain strobes with address and data.

Top module: `rx_ring_mgr`

## Requirements
- R1: Descriptor layout: bits 61:48 hold the length, bit 47 holds the timestamp flag, bits 46:40 hold the status code and bits 39:0 hold the buffer address. Bits 63:62 are written back as zero. Write-back keeps the address and the timestamp flag of the posted descriptor.
- R2: A frame that fits in one buffer writes its bytes in order to that buffer's address plus 0, 1, 2 and so on. The descriptor is written back with code 0x0F and the frame's byte count as its length.
- R3: A frame longer than its buffer fills that buffer and writes the descriptor back with code 0x10 and the full buffer length. The frame continues at the next descriptor's address. The last buffer gets code 0x0F and the length of the remainder.
- R4: Descriptor indices run from 0 to size-1 and then wrap to 0. The write-back address is (base × 8) + (index × 8).
- R5: A doorbell write of N adds N to the count of available descriptors. Each descriptor written back subtracts one from that count.
- R6: A frame that starts while no descriptor is available makes no payload or descriptor writes, and it adds one to the drop counter.
- R7: If a buffer fills, the frame has not ended and no further descriptor is available, that descriptor is written back with code 0x7F and the buffer length. The rest of the frame, up to its end marker, is discarded.
- R8: Every frame closed with code 0x0F or 0x7F adds one to the completion counter. An acknowledge write of N subtracts N, and the counter stops at zero instead of going below it.
- R9: The interrupt is set on a completion that leaves the counter above the watermark. With a watermark of 0, every frame sets it.
- R10: Writing the clear input removes the interrupt. The interrupt is set again only by a later completion, even if the counter is still above the watermark.
- R11: Bytes that arrive with no start marker while no frame is in progress are ignored.
- R12: After reset, all counters read zero, the interrupt is low and no strobes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 37 | Ring base address shifted right by 3 |
| cfg_size_i | input | CNT_W | Ring size in entries |
| wmark_i | input | CNT_W | Completion watermark for the interrupt |
| sw_we_i | input | 1 | Software descriptor write strobe |
| sw_idx_i | input | IDX_W | Descriptor index for software write and read |
| sw_wdata_i | input | 64 | Descriptor value to write |
| sw_rdata_o | output | 64 | Descriptor stored at sw_idx_i |
| bell_we_i | input | 1 | Doorbell write strobe |
| bell_val_i | input | CNT_W | Number of descriptors being posted |
| ack_we_i | input | 1 | Completion acknowledge write strobe |
| ack_val_i | input | CNT_W | Number of completions acknowledged |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| rx_valid_i | input | 1 | Byte valid |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_data_i | input | 8 | Frame byte |
| pay_we_o | output | 1 | Payload write strobe |
| pay_addr_o | output | 40 | Payload byte address |
| pay_data_o | output | 8 | Payload byte |
| wb_valid_o | output | 1 | Descriptor write-back strobe |
| wb_addr_o | output | 40 | Byte address of the written-back descriptor |
| wb_desc_o | output | 64 | Written-back descriptor value |
| avail_o | output | CNT_W | Posted descriptors not yet used |
| cmpl_cnt_o | output | CNT_W | Completion counter |
| drop_cnt_o | output | DROP_W | Count of dropped frames |
| irq_o | output | 1 | Interrupt flag |

## Verification
On every cycle, the assertions check that write-back codes are legal and lengths are nonzero, that the interrupt only rises together with a closing write-back and only falls after a clear, and that the drop counter changes only after a start beat. They also check that the completion counter only falls after an acknowledge and that the available count never exceeds the ring size. The bench scenarios are needed to show the byte-by-byte payload addressing, how the lengths split when a frame spans buffers, the wrapped write-back address, the running-out case, acknowledges that stop at zero, and the exact watermark threshold at which the interrupt fires again.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int LEN_W  = 14;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 40;
  localparam int DESC_W = 64;

  localparam logic [CODE_W-1:0] CODE_DONE = 7'h0F;
  localparam logic [CODE_W-1:0] CODE_MORE = 7'h10;
  localparam logic [CODE_W-1:0] CODE_ERR  = 7'h7F;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic [LEN_W-1:0]  len;
    logic              ts;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
  } rx_desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_NEXT, ST_SKIP} eng_st_e;
endpackage

// File: rtl/rx_desc_ram.sv
module rx_desc_ram #(
  parameter int DEPTH  = 16,
  parameter int DESC_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              hw_we_i,
  input  logic [IDX_W-1:0]  hw_idx_i,
  input  logic [DESC_W-1:0] hw_wdata_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [DESC_W-1:0] sw_wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DESC_W-1:0] rd_data_o,
  output logic [DESC_W-1:0] sw_rdata_o
);
  logic [DESC_W-1:0] mem_q [DEPTH];

  // hardware write-back wins a same-entry collision
  always_ff @(posedge clk_i) begin
    if (hw_we_i) mem_q[hw_idx_i] <= hw_wdata_i;
    if (sw_we_i && !(hw_we_i && hw_idx_i == sw_idx_i)) mem_q[sw_idx_i] <= sw_wdata_i;
  end

  assign rd_data_o  = mem_q[rd_idx_i];
  assign sw_rdata_o = mem_q[sw_idx_i];
endmodule

// File: rtl/rx_credit_ctr.sv
module rx_credit_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_en_i,
  input  logic [CNT_W-1:0] add_val_i,
  input  logic             sub_one_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + (add_en_i ? add_val_i : '0) - CNT_W'(sub_one_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_cmpl_unit.sv
module rx_cmpl_unit #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ack_we_i,
  input  logic [CNT_W-1:0] ack_val_i,
  input  logic [CNT_W-1:0] wmark_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum, sub, nxt;
  logic             irq_q;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
    sub = ack_we_i ? {1'b0, ack_val_i} : '0;
    nxt = (sub >= sum) ? '0 : sum - sub;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= nxt[CNT_W-1:0];
      // a completion above the watermark takes priority over a clear
      if (inc_i && nxt > {1'b0, wmark_i}) irq_q <= 1'b1;
      else if (irq_clr_i)                 irq_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/rx_frame_eng.sv
module rx_frame_eng
  import rx_ring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_size_i,
  input  logic [CNT_W-1:0]  avail_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  rx_desc_t          head_desc_i,
  output logic [IDX_W-1:0]  head_o,
  output logic              close_o,
  output logic              cmpl_inc_o,
  output rx_desc_t          close_desc_o,
  output logic              pay_we_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output rx_desc_t          wb_desc_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  eng_st_e           st_q, st_d;
  logic [IDX_W-1:0]  head_q;
  logic [CNT_W-1:0]  head_inc;
  logic [ADDR_W-1:0] cur_addr_q, base_addr;
  logic [LEN_W-1:0]  cnt_q, buf_len_q, off, new_cnt, buf_len;
  logic              ts_q, ts_cur;
  logic              open_buf, byte_en, full, drop;
  logic [CODE_W-1:0] code;
  logic              pay_we_q, wb_valid_q;
  logic [ADDR_W-1:0] pay_addr_q;
  logic [7:0]        pay_data_q;
  logic [IDX_W-1:0]  wb_idx_q;
  rx_desc_t          wb_desc_q;
  logic [DROP_W-1:0] drop_q;

  always_comb begin
    open_buf  = rx_valid_i && ((st_q == ST_IDLE && rx_sof_i && avail_i != '0) || st_q == ST_NEXT);
    byte_en   = open_buf || (rx_valid_i && st_q == ST_FILL);
    drop      = rx_valid_i && st_q == ST_IDLE && rx_sof_i && avail_i == '0;
    base_addr = open_buf ? head_desc_i.addr : cur_addr_q;
    off       = open_buf ? '0 : cnt_q;
    new_cnt   = off + LEN_W'(1);
    buf_len   = open_buf ? head_desc_i.len : buf_len_q;
    ts_cur    = open_buf ? head_desc_i.ts : ts_q;
    full      = new_cnt >= buf_len;
    // avail_i still includes the descriptor being closed
    if (rx_eof_i)                  code = CODE_DONE;
    else if (avail_i > CNT_W'(1))  code = CODE_MORE;
    else                           code = CODE_ERR;
    close_o    = byte_en && (rx_eof_i || full);
    cmpl_inc_o = close_o && code != CODE_MORE;

    close_desc_o      = '0;
    close_desc_o.len  = new_cnt;
    close_desc_o.ts   = ts_cur;
    close_desc_o.code = code;
    close_desc_o.addr = base_addr;

    head_inc = {1'b0, head_q} + CNT_W'(1);

    st_d = st_q;
    if (close_o) begin
      if (code == CODE_DONE)      st_d = ST_IDLE;
      else if (code == CODE_MORE) st_d = ST_NEXT;
      else                        st_d = ST_SKIP;
    end else if (byte_en) begin
      st_d = ST_FILL;
    end else if (drop && !rx_eof_i) begin
      st_d = ST_SKIP;
    end else if (st_q == ST_SKIP && rx_valid_i && rx_eof_i) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      head_q     <= '0;
      cur_addr_q <= '0;
      cnt_q      <= '0;
      buf_len_q  <= '0;
      ts_q       <= 1'b0;
      pay_we_q   <= 1'b0;
      pay_addr_q <= '0;
      pay_data_q <= '0;
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_desc_q  <= '0;
      drop_q     <= '0;
    end else begin
      st_q <= st_d;
      if (byte_en) begin
        cur_addr_q <= base_addr;
        cnt_q      <= new_cnt;
        buf_len_q  <= buf_len;
        ts_q       <= ts_cur;
      end
      if (close_o) head_q <= (head_inc == cfg_size_i) ? '0 : head_inc[IDX_W-1:0];
      pay_we_q   <= byte_en;
      pay_addr_q <= base_addr + ADDR_W'(off);
      pay_data_q <= rx_data_i;
      wb_valid_q <= close_o;
      wb_idx_q   <= head_q;
      wb_desc_q  <= close_desc_o;
      if (drop) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign head_o     = head_q;
  assign pay_we_o   = pay_we_q;
  assign pay_addr_o = pay_addr_q;
  assign pay_data_o = pay_data_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_idx_o   = wb_idx_q;
  assign wb_desc_o  = wb_desc_q;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DROP_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int BASE_W = ADDR_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [CNT_W-1:0]  cfg_size_i,
  input  logic [CNT_W-1:0]  wmark_i,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [DESC_W-1:0] sw_wdata_i,
  output logic [DESC_W-1:0] sw_rdata_o,
  input  logic              bell_we_i,
  input  logic [CNT_W-1:0]  bell_val_i,
  input  logic              ack_we_i,
  input  logic [CNT_W-1:0]  ack_val_i,
  input  logic              irq_clr_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  output logic              pay_we_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DESC_W-1:0] wb_desc_o,
  output logic [CNT_W-1:0]  avail_o,
  output logic [CNT_W-1:0]  cmpl_cnt_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  head, wb_idx;
  logic [DESC_W-1:0] head_word;
  rx_desc_t          head_desc, close_desc, wb_desc;
  logic              close, cmpl_inc;

  assign head_desc = rx_desc_t'(head_word);

  rx_desc_ram #(.DEPTH(DEPTH), .DESC_W(DESC_W)) u_ram (
    .clk_i      (clk_i),
    .hw_we_i    (close),
    .hw_idx_i   (head),
    .hw_wdata_i (close_desc),
    .sw_we_i    (sw_we_i),
    .sw_idx_i   (sw_idx_i),
    .sw_wdata_i (sw_wdata_i),
    .rd_idx_i   (head),
    .rd_data_o  (head_word),
    .sw_rdata_o (sw_rdata_o)
  );

  rx_credit_ctr #(.CNT_W(CNT_W)) u_credit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_en_i  (bell_we_i),
    .add_val_i (bell_val_i),
    .sub_one_i (close),
    .cnt_o     (avail_o)
  );

  rx_frame_eng #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_size_i   (cfg_size_i),
    .avail_i      (avail_o),
    .rx_valid_i   (rx_valid_i),
    .rx_sof_i     (rx_sof_i),
    .rx_eof_i     (rx_eof_i),
    .rx_data_i    (rx_data_i),
    .head_desc_i  (head_desc),
    .head_o       (head),
    .close_o      (close),
    .cmpl_inc_o   (cmpl_inc),
    .close_desc_o (close_desc),
    .pay_we_o     (pay_we_o),
    .pay_addr_o   (pay_addr_o),
    .pay_data_o   (pay_data_o),
    .wb_valid_o   (wb_valid_o),
    .wb_idx_o     (wb_idx),
    .wb_desc_o    (wb_desc),
    .drop_cnt_o   (drop_cnt_o)
  );

  rx_cmpl_unit #(.CNT_W(CNT_W)) u_cmpl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (cmpl_inc),
    .ack_we_i  (ack_we_i),
    .ack_val_i (ack_val_i),
    .wmark_i   (wmark_i),
    .irq_clr_i (irq_clr_i),
    .cnt_o     (cmpl_cnt_o),
    .irq_o     (irq_o)
  );

  assign wb_desc_o = wb_desc;
  assign wb_addr_o = {cfg_base_i, 3'b000} + {{(ADDR_W-IDX_W-3){1'b0}}, wb_idx, 3'b000};
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int CNT_W  = 5,
  parameter int DROP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_sof_i,
  input logic              ack_we_i,
  input logic              irq_clr_i,
  input logic [CNT_W-1:0]  cfg_size_i,
  input logic              wb_valid_o,
  input logic [63:0]       wb_desc_o,
  input logic [CNT_W-1:0]  avail_o,
  input logic [CNT_W-1:0]  cmpl_cnt_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic              irq_o
);
  assert_code_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_desc_o[46:40] == 7'h0F || wb_desc_o[46:40] == 7'h10 || wb_desc_o[46:40] == 7'h7F));

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_desc_o[63:62] == 2'b00);

  assert_len_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_desc_o[61:48] != 14'd0);

  assert_avail_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o <= cfg_size_i);

  assert_drop_on_sof_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> $past(rx_valid_i && rx_sof_i));

  assert_dec_on_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_cnt_o < $past(cmpl_cnt_o)) |-> $past(ack_we_i));

  assert_irq_on_cmpl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (wb_valid_o && wb_desc_o[46:40] != 7'h10));

  assert_irq_fall_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_sof_i   (rx_sof_i),
  .ack_we_i   (ack_we_i),
  .irq_clr_i  (irq_clr_i),
  .cfg_size_i (cfg_size_i),
  .wb_valid_o (wb_valid_o),
  .wb_desc_o  (wb_desc_o),
  .avail_o    (avail_o),
  .cmpl_cnt_o (cmpl_cnt_o),
  .drop_cnt_o (drop_cnt_o),
  .irq_o      (irq_o)
);

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;
  localparam int IDX_W = 4;
  localparam int CNT_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [36:0] cfg_base = 37'h100;
  logic [CNT_W-1:0] cfg_size = 5'd4;
  logic [CNT_W-1:0] wmark = '0;
  logic        sw_we = 1'b0;
  logic [IDX_W-1:0] sw_idx = '0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] sw_rdata;
  logic        bell_we = 1'b0;
  logic [CNT_W-1:0] bell_val = '0;
  logic        ack_we = 1'b0;
  logic [CNT_W-1:0] ack_val = '0;
  logic        irq_clr = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        pay_we_o, wb_valid_o, irq_o;
  logic [39:0] pay_addr_o, wb_addr_o;
  logic [7:0]  pay_data_o;
  logic [63:0] wb_desc_o;
  logic [CNT_W-1:0] avail_o, cmpl_cnt_o;
  logic [15:0] drop_cnt_o;

  int total = 0, bad = 0;
  int pay_n = 0, wb_n = 0;
  logic [39:0] pa [32];
  logic [7:0]  pd [32];
  logic [39:0] wa [8];
  logic [63:0] wd [8];

  always #4 clk = ~clk;

  rx_ring_mgr u_rx_ring_mgr (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size),
    .wmark_i(wmark), .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .bell_we_i(bell_we), .bell_val_i(bell_val),
    .ack_we_i(ack_we), .ack_val_i(ack_val), .irq_clr_i(irq_clr),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
    .pay_we_o(pay_we_o), .pay_addr_o(pay_addr_o), .pay_data_o(pay_data_o),
    .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .wb_desc_o(wb_desc_o),
    .avail_o(avail_o), .cmpl_cnt_o(cmpl_cnt_o), .drop_cnt_o(drop_cnt_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (pay_we_o) begin
      if (pay_n < 32) begin pa[pay_n] = pay_addr_o; pd[pay_n] = pay_data_o; end
      pay_n++;
    end
    if (wb_valid_o) begin
      if (wb_n < 8) begin wa[wb_n] = wb_addr_o; wd[wb_n] = wb_desc_o; end
      wb_n++;
    end
  end

  function automatic logic [63:0] mk(input int len, input logic ts, input logic [6:0] code,
                                     input logic [39:0] a);
    return {2'b00, 14'(len), ts, code, a};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    pay_n = 0;
    wb_n = 0;
  endtask

  task automatic wr_desc(input int idx, input logic [63:0] d);
    @(negedge clk); sw_we = 1'b1; sw_idx = IDX_W'(idx); sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic ring(input int n);
    @(negedge clk); bell_we = 1'b1; bell_val = CNT_W'(n);
    @(negedge clk); bell_we = 1'b0;
  endtask

  task automatic ack(input int n);
    @(negedge clk); ack_we = 1'b1; ack_val = CNT_W'(n);
    @(negedge clk); ack_we = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] seed, input logic with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = with_sof && (i == 0); rx_eof = (i == n - 1);
      rx_data = seed + 8'(i);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 cmpl", 64'(cmpl_cnt_o), 0);
    chk("R12 drop", 64'(drop_cnt_o), 0);
    chk("R12 avail", 64'(avail_o), 0);
    chk("R12 irq", 64'(irq_o), 0);
    chk("R12 strobes", 64'({pay_we_o, wb_valid_o}), 0);
  endtask

  task automatic t_post();
    wr_desc(0, mk(8, 1'b0, 7'h0, 40'h1000));
    wr_desc(1, mk(8, 1'b1, 7'h0, 40'h2000));
    wr_desc(2, mk(8, 1'b0, 7'h0, 40'h3000));
    wr_desc(3, mk(8, 1'b0, 7'h0, 40'h4000));
    ring(4);
    chk("R5 avail after bell", 64'(avail_o), 4);
    @(negedge clk); sw_idx = 4'd1; #1;
    chk("R1 stored desc", sw_rdata, mk(8, 1'b1, 7'h0, 40'h2000));
  endtask

  task automatic t_single();
    clr_logs();
    send(5, 8'hA0, 1'b1);
    chk("R2 pay count", 64'(pay_n), 5);
    chk("R2 pay addr0", 64'(pa[0]), 64'h1000);
    chk("R2 pay addr4", 64'(pa[4]), 64'h1004);
    chk("R2 pay data4", 64'(pd[4]), 64'hA4);
    chk("R2 wb count", 64'(wb_n), 1);
    chk("R2 wb desc", wd[0], mk(5, 1'b0, 7'h0F, 40'h1000));
    chk("R4 wb addr idx0", 64'(wa[0]), 64'h800);
    @(negedge clk); sw_idx = 4'd0; #1;
    chk("R1 ring content", sw_rdata, mk(5, 1'b0, 7'h0F, 40'h1000));
    chk("R5 avail after use", 64'(avail_o), 3);
    chk("R8 cmpl inc", 64'(cmpl_cnt_o), 1);
    chk("R9 irq wmark0", 64'(irq_o), 1);
  endtask

  task automatic t_clear_ack();
    clear_irq();
    chk("R10 irq cleared", 64'(irq_o), 0);
    ack(1);
    chk("R8 ack sub", 64'(cmpl_cnt_o), 0);
    chk("R10 irq stays low", 64'(irq_o), 0);
  endtask

  task automatic t_span();
    clr_logs();
    send(20, 8'h10, 1'b1);
    chk("R3 pay count", 64'(pay_n), 20);
    chk("R3 pay addr8", 64'(pa[8]), 64'h3000);
    chk("R3 pay addr19", 64'(pa[19]), 64'h4003);
    chk("R3 pay data19", 64'(pd[19]), 64'h23);
    chk("R3 wb count", 64'(wb_n), 3);
    chk("R3 wb0 more keeps ts", wd[0], mk(8, 1'b1, 7'h10, 40'h2000));
    chk("R3 wb1 more", wd[1], mk(8, 1'b0, 7'h10, 40'h3000));
    chk("R3 wb2 done", wd[2], mk(4, 1'b0, 7'h0F, 40'h4000));
    chk("R4 wb addr idx3", 64'(wa[2]), 64'h818);
    chk("R8 one frame one cmpl", 64'(cmpl_cnt_o), 1);
    chk("R5 avail zero", 64'(avail_o), 0);
    clear_irq();
    ack(1);
  endtask

  task automatic t_drop();
    clr_logs();
    send(3, 8'h55, 1'b1);
    chk("R6 drop count", 64'(drop_cnt_o), 1);
    chk("R6 no payload", 64'(pay_n), 0);
    chk("R6 no wb", 64'(wb_n), 0);
  endtask

  task automatic t_wrap();
    wr_desc(0, mk(8, 1'b0, 7'h0, 40'h5000));
    ring(1);
    clr_logs();
    send(2, 8'h60, 1'b1);
    chk("R4 wrapped wb addr", 64'(wa[0]), 64'h800);
    chk("R4 wrapped pay addr", 64'(pa[0]), 64'h5000);
    chk("R2 wrapped wb desc", wd[0], mk(2, 1'b0, 7'h0F, 40'h5000));
    clear_irq();
    ack(1);
  endtask

  task automatic t_runout();
    wr_desc(1, mk(4, 1'b0, 7'h0, 40'h6000));
    ring(1);
    clr_logs();
    send(10, 8'h70, 1'b1);
    chk("R7 pay stops", 64'(pay_n), 4);
    chk("R7 wb count", 64'(wb_n), 1);
    chk("R7 err desc", wd[0], mk(4, 1'b0, 7'h7F, 40'h6000));
    chk("R7 err counts cmpl", 64'(cmpl_cnt_o), 1);
    clr_logs();
    send(2, 8'h80, 1'b1);
    chk("R6 next frame dropped", 64'(drop_cnt_o), 2);
    chk("R7 discard no payload", 64'(pay_n), 0);
    clear_irq();
    ack(1);
  endtask

  task automatic t_stray();
    wr_desc(2, mk(8, 1'b0, 7'h0, 40'h7000));
    ring(1);
    clr_logs();
    send(3, 8'h90, 1'b0);
    chk("R11 stray no payload", 64'(pay_n), 0);
    chk("R11 stray avail kept", 64'(avail_o), 1);
    send(1, 8'h99, 1'b1);
    chk("R11 later frame ok", wd[0], mk(1, 1'b0, 7'h0F, 40'h7000));
    ack(5);
    chk("R8 ack saturates", 64'(cmpl_cnt_o), 0);
    clear_irq();
  endtask

  task automatic t_wmark();
    wmark = 5'd2;
    wr_desc(3, mk(8, 1'b0, 7'h0, 40'h8000));
    wr_desc(0, mk(8, 1'b0, 7'h0, 40'h8100));
    wr_desc(1, mk(8, 1'b0, 7'h0, 40'h8200));
    wr_desc(2, mk(8, 1'b0, 7'h0, 40'h8300));
    ring(4);
    send(1, 8'h01, 1'b1);
    send(1, 8'h02, 1'b1);
    chk("R9 at wmark no irq", 64'(irq_o), 0);
    send(1, 8'h03, 1'b1);
    chk("R9 above wmark irq", 64'(irq_o), 1);
    clear_irq();
    repeat (4) @(negedge clk);
    chk("R10 no reassert w/o cmpl", 64'(irq_o), 0);
    send(1, 8'h04, 1'b1);
    chk("R10 reassert on cmpl", 64'(irq_o), 1);
    chk("R8 count four", 64'(cmpl_cnt_o), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_single();
    t_clear_ack();
    t_span();
    t_drop();
    t_wrap();
    t_runout();
    t_stray();
    t_wmark();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule